// File: doc/BRIEF.md
# Tagged Serial Character Receiver

This block recovers asynchronous serial characters from a single line. It is clocked by the system clock. It advances only on a one-cycle tick that arrives sixteen times per bit period from an external rate generator. A low level that is still low half a bit later counts as a start. The block then collects 5 to 8 data bits, checks an optional parity bit and samples the stop level. It hands each character out as one 11-bit word, with that character's own error flags held in fixed positions, so that downstream storage keeps every flag next to its data.

A select input switches the receiver from the external pin to the local transmitter output, which allows on-chip loopback testing. An idle watchdog emits one pulse once the line has stayed quiet for a programmed number of character times after the last character. The downstream logic can use that pulse to flush a partly filled buffer.

Top module: `uart_rx_tagger`

## Requirements
- R1: After the line falls, the receiver tests it again on the 8th tick. If the line has returned high by then, the receiver drops back to idle and emits no word.
- R2: Data bits are sampled once every 16 ticks, starting from the validated start point, least significant bit first, and appear in `rx_word[7:0]`.
- R3: `cfg_len` selects the character length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits above the selected length read as zero.
- R4: When `cfg_par_en` is 1, one parity bit follows the data. `cfg_par_even` = 1 means the data plus parity must hold an even number of ones, and 0 means an odd number. A mismatch sets `rx_word[9]`. Bit 9 is always 0 when parity is disabled.
- R5: A low stop sample sets the framing flag `rx_word[8]`.
- R6: A character whose data, parity and stop samples are all low sets the break flag `rx_word[10]`, together with bit 8 and zero data. The receiver then accepts no new start until the line has been seen high.
- R7: Each character produces exactly one `rx_stb` pulse, one cycle wide, and `rx_word` is valid in that cycle.
- R8: With `lb_sel` = 1 the receiver listens to `lb_tx` and ignores `rx_pin`. With `lb_sel` = 0 it listens to `rx_pin`.
- R9: If `cfg_idle` is N (nonzero), one `idle_pulse` fires after the line has been idle for N character times following the last strobe. One character time is 16 × (2 + data bits + parity bit) ticks. The pulse fires again only after another character has been received.
- R10: With `cfg_idle` = 0, no `idle_pulse` is produced.
- R11: After reset, `rx_stb` and `idle_pulse` are low, and no word is emitted while the line stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle tick, 16 per bit period |
| rx_pin | input | 1 | External serial line, idles high |
| lb_tx | input | 1 | Local transmitter output, used when looping back |
| lb_sel | input | 1 | 1 selects `lb_tx` as the receive source |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| cfg_len | input | 2 | Data length code, 0..3 for 5..8 bits |
| cfg_idle | input | 5 | Idle limit in character times, 0 disables |
| rx_stb | output | 1 | One-cycle strobe for a received character |
| rx_word | output | 11 | {break, parity error, framing error, data[7:0]} |
| idle_pulse | output | 1 | One-cycle idle timeout pulse |

## Verification
The bench sends a short low glitch, which a receiver that skipped the mid-start recheck would turn into a spurious word. It holds the line low well past a whole frame. A receiver that failed to wait for the line to go high again would report a second break, and one that mis-tagged the frame would lose either the break flag or its framing flag. It sends short characters, where missing zeroing of the unused data bits would leave stale high bits. It sends both good and bad parity in each polarity, which exposes an inverted polarity or an error flag raised while parity is off. Finally, it times the idle pulse against early, on-time and repeated windows, and drives the unused line low during loopback to expose a wrong source select.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
   localparam int DATA_W   = 8;
   localparam int WORD_W   = 11;
   localparam int POS_FERR = 8;
   localparam int POS_PERR = 9;
   localparam int POS_BRK  = 10;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP,
      ST_BRKWAIT
   } rx_state_e;
endpackage

// File: rtl/rx_line_front.sv
module rx_line_front #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic lb_tx,
   input  logic lb_sel,
   output logic line_o
);
   logic src;
   assign src = lb_sel ? lb_tx : pin;

   if (SYNC_STAGES > 4) begin : g_bad_depth
      $error("rx_line_front: SYNC_STAGES must be 0..4");
   end

   if (SYNC_STAGES == 0) begin : g_direct
      assign line_o = src;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain <= '1;
         end else begin
            chain[0] <= src;
            for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
         end
      end
      assign line_o = chain[SYNC_STAGES-1];
   end
endmodule

// File: rtl/rx_frame_core.sv
module rx_frame_core
   import uart_rx_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              line,
   input  logic              par_en,
   input  logic              par_even,
   input  logic [1:0]        len,
   output logic              done,
   output logic [WORD_W-1:0] word,
   output logic              busy
);
   localparam int TW   = $clog2(OVS);
   localparam int HALF = OVS / 2;

   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("rx_frame_core: OVS must be even and at least 4");
   end

   rx_state_e         state;
   logic [TW-1:0]     tcnt;
   logic [2:0]        bidx;
   logic [DATA_W-1:0] data;
   logic              pbit;
   logic [1:0]        len_q;
   logic              pen_q;
   logic              pev_q;

   logic       at_half, at_full, ferr, perr, brk;
   logic [2:0] last_idx;

   assign at_half  = (tcnt == TW'(HALF - 1));
   assign at_full  = (tcnt == TW'(OVS - 1));
   assign last_idx = {1'b0, len_q} + 3'd4;
   assign ferr     = !line;
   assign perr     = pen_q && ((^data ^ pbit) ^ !pev_q);
   assign brk      = (data == '0) && !pbit && !line;
   assign busy     = (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         tcnt  <= '0;
         bidx  <= '0;
         data  <= '0;
         pbit  <= 1'b0;
         len_q <= 2'd3;
         pen_q <= 1'b0;
         pev_q <= 1'b0;
         done  <= 1'b0;
         word  <= '0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            unique case (state)
               ST_IDLE: begin
                  if (!line) begin
                     state <= ST_START;
                     tcnt  <= '0;
                  end
               end
               ST_START: begin
                  if (at_half) begin
                     tcnt <= '0;
                     if (!line) begin
                        state <= ST_DATA;
                        data  <= '0;
                        pbit  <= 1'b0;
                        bidx  <= '0;
                        len_q <= len;
                        pen_q <= par_en;
                        pev_q <= par_even;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
               ST_DATA: begin
                  if (at_full) begin
                     tcnt       <= '0;
                     data[bidx] <= line;
                     if (bidx == last_idx) state <= pen_q ? ST_PAR : ST_STOP;
                     else                  bidx  <= bidx + 1'b1;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
               ST_PAR: begin
                  if (at_full) begin
                     tcnt  <= '0;
                     pbit  <= line;
                     state <= ST_STOP;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
               ST_STOP: begin
                  if (at_full) begin
                     tcnt  <= '0;
                     done  <= 1'b1;
                     word  <= {brk, perr, ferr, data};
                     state <= brk ? ST_BRKWAIT : ST_IDLE;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
               ST_BRKWAIT: begin
                  if (line) state <= ST_IDLE;
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   AST_BRK_IMPLIES_FERR: assert property (@(posedge clk) disable iff (!rst_n)
      (done && word[POS_BRK]) |-> (word[POS_FERR] && word[DATA_W-1:0] == '0)); // R6
   AST_UNUSED_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((word[DATA_W-1:0] >> ({2'b00, len_q} + 4'd5)) == '0)); // R3
   AST_PERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !pen_q) |-> !word[POS_PERR]); // R4
   AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7
   AST_BRKWAIT_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_BRKWAIT) |=> !done); // R6
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
   parameter int OVS   = 16,
   parameter int LIM_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             busy,
   input  logic             done,
   input  logic [1:0]       len,
   input  logic             par_en,
   input  logic [LIM_W-1:0] limit,
   output logic             pulse
);
   localparam int CW = $clog2(OVS * 11 + 1);

   if (LIM_W < 1) begin : g_bad_lim
      $error("rx_idle_timer: LIM_W must be at least 1");
   end

   logic [CW-1:0]    char_ticks;
   logic [CW-1:0]    tk;
   logic [LIM_W-1:0] ch;
   logic             armed;

   assign char_ticks = CW'(OVS) * (CW'(7) + CW'(len) + CW'(par_en));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tk    <= '0;
         ch    <= '0;
         armed <= 1'b0;
         pulse <= 1'b0;
      end else begin
         pulse <= 1'b0;
         if (done) begin
            armed <= 1'b1;
            tk    <= '0;
            ch    <= '0;
         end else if (busy) begin
            tk <= '0;
            ch <= '0;
         end else if (armed && limit != '0 && tick) begin
            if (tk == char_ticks - 1'b1) begin
               tk <= '0;
               if (ch == limit - 1'b1) begin
                  pulse <= 1'b1;
                  armed <= 1'b0;
                  ch    <= '0;
               end else begin
                  ch <= ch + 1'b1;
               end
            end else begin
               tk <= tk + 1'b1;
            end
         end
      end
   end

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse); // R9
   AST_ZERO_LIMIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (limit == '0 && $past(limit) == '0) |-> !pulse); // R10
endmodule

// File: rtl/uart_rx_tagger.sv
module uart_rx_tagger
   import uart_rx_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2,
   parameter int TMO_W       = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick16,
   input  logic              rx_pin,
   input  logic              lb_tx,
   input  logic              lb_sel,
   input  logic              cfg_par_en,
   input  logic              cfg_par_even,
   input  logic [1:0]        cfg_len,
   input  logic [TMO_W-1:0]  cfg_idle,
   output logic              rx_stb,
   output logic [WORD_W-1:0] rx_word,
   output logic              idle_pulse
);
   logic line, busy;

   rx_line_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin    (rx_pin),
      .lb_tx  (lb_tx),
      .lb_sel (lb_sel),
      .line_o (line)
   );

   rx_frame_core #(.OVS(OVS)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick16),
      .line     (line),
      .par_en   (cfg_par_en),
      .par_even (cfg_par_even),
      .len      (cfg_len),
      .done     (rx_stb),
      .word     (rx_word),
      .busy     (busy)
   );

   rx_idle_timer #(.OVS(OVS), .LIM_W(TMO_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick16),
      .busy   (busy),
      .done   (rx_stb),
      .len    (cfg_len),
      .par_en (cfg_par_en),
      .limit  (cfg_idle),
      .pulse  (idle_pulse)
   );

   AST_NO_STB_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !rx_stb && !idle_pulse); // R11
endmodule

// File: tb/sim_uart_rx_tagger.sv
module sim_uart_rx_tagger;
   localparam int CLK_PERIOD = 10;
   localparam int TICK_DIV   = 4;
   localparam int BIT_CLKS   = 16 * TICK_DIV;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick16 = 1'b0;
   logic        rx_pin = 1'b1;
   logic        lb_tx = 1'b1;
   logic        lb_sel = 1'b0;
   logic        cfg_par_en = 1'b0;
   logic        cfg_par_even = 1'b1;
   logic [1:0]  cfg_len = 2'd3;
   logic [4:0]  cfg_idle = 5'd0;
   logic        rx_stb;
   logic [10:0] rx_word;
   logic        idle_pulse;

   int total = 0;
   int bad = 0;
   int n_words = 0;
   int n_pulse = 0;
   logic [10:0] got_word = '0;
   int tdiv = 0;

   uart_rx_tagger u0 (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_pin(rx_pin),
      .lb_tx(lb_tx), .lb_sel(lb_sel), .cfg_par_en(cfg_par_en),
      .cfg_par_even(cfg_par_even), .cfg_len(cfg_len), .cfg_idle(cfg_idle),
      .rx_stb(rx_stb), .rx_word(rx_word), .idle_pulse(idle_pulse)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) begin
      tdiv   <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
      tick16 <= (tdiv == TICK_DIV - 1);
      if (rx_stb) begin
         got_word <= rx_word;
         n_words  <= n_words + 1;
      end
      if (idle_pulse) n_pulse <= n_pulse + 1;
   end

   task automatic check(input string req, input logic ok, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic hold(input logic v, input int clks, input logic via_lb);
      if (via_lb) lb_tx = v; else rx_pin = v;
      repeat (clks) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] d, input int nbits, input logic pen,
                       input logic pb, input logic stopv, input logic via_lb);
      hold(1'b0, BIT_CLKS, via_lb);
      for (int i = 0; i < nbits; i++) hold(d[i], BIT_CLKS, via_lb);
      if (pen) hold(pb, BIT_CLKS, via_lb);
      hold(stopv, BIT_CLKS, via_lb);
      hold(1'b1, 2 * BIT_CLKS, via_lb);
   endtask

   task automatic expect_word(input string req, input int w0, input logic [10:0] exp);
      check(req, n_words == w0 + 1, n_words - w0, 1);
      check(req, got_word == exp, int'(got_word), int'(exp));
   endtask

   task automatic t_reset();
      check("R11 stb", rx_stb == 1'b0, int'(rx_stb), 0);
      check("R11 pulse", idle_pulse == 1'b0, int'(idle_pulse), 0);
      repeat (200) @(negedge clk);
      check("R11 no word", n_words == 0, n_words, 0);
   endtask

   task automatic t_byte();
      int w0;
      cfg_len = 2'd3; cfg_par_en = 1'b0;
      w0 = n_words; send(8'hA5, 8, 1'b0, 1'b0, 1'b1, 1'b0);
      expect_word("R2 0xA5", w0, 11'h0A5);
      w0 = n_words; send(8'h3C, 8, 1'b0, 1'b0, 1'b1, 1'b0);
      expect_word("R7 0x3C", w0, 11'h03C);
   endtask

   task automatic t_short();
      int w0;
      cfg_len = 2'd0;
      w0 = n_words; send(8'hFB, 5, 1'b0, 1'b0, 1'b1, 1'b0);
      expect_word("R3 len5", w0, 11'h01B);
      cfg_len = 2'd2;
      w0 = n_words; send(8'hD5, 7, 1'b0, 1'b0, 1'b1, 1'b0);
      expect_word("R3 len7", w0, 11'h055);
      cfg_len = 2'd3;
   endtask

   task automatic t_parity();
      int w0;
      cfg_len = 2'd3; cfg_par_en = 1'b1;
      cfg_par_even = 1'b1;
      w0 = n_words; send(8'h5A, 8, 1'b1, 1'b0, 1'b1, 1'b0);
      expect_word("R4 even ok", w0, 11'h05A);
      w0 = n_words; send(8'h5A, 8, 1'b1, 1'b1, 1'b1, 1'b0);
      expect_word("R4 even bad", w0, 11'h25A);
      cfg_par_even = 1'b0;
      w0 = n_words; send(8'h5A, 8, 1'b1, 1'b1, 1'b1, 1'b0);
      expect_word("R4 odd ok", w0, 11'h05A);
      w0 = n_words; send(8'h5A, 8, 1'b1, 1'b0, 1'b1, 1'b0);
      expect_word("R4 odd bad", w0, 11'h25A);
      cfg_par_en = 1'b0; cfg_par_even = 1'b1;
   endtask

   task automatic t_framing();
      int w0;
      w0 = n_words; send(8'h81, 8, 1'b0, 1'b0, 1'b0, 1'b0);
      expect_word("R5 stop low", w0, 11'h181);
   endtask

   task automatic t_break();
      int w0;
      cfg_par_en = 1'b1; cfg_par_even = 1'b1;
      w0 = n_words;
      hold(1'b0, 14 * BIT_CLKS, 1'b0);
      hold(1'b1, 2 * BIT_CLKS, 1'b0);
      expect_word("R6 break", w0, 11'h500);
      cfg_par_en = 1'b0;
      w0 = n_words; send(8'h42, 8, 1'b0, 1'b0, 1'b1, 1'b0);
      expect_word("R6 after break", w0, 11'h042);
   endtask

   task automatic t_false_start();
      int w0;
      w0 = n_words;
      hold(1'b0, 5 * TICK_DIV, 1'b0);
      hold(1'b1, 2 * BIT_CLKS, 1'b0);
      check("R1 glitch ignored", n_words == w0, n_words - w0, 0);
      w0 = n_words; send(8'h99, 8, 1'b0, 1'b0, 1'b1, 1'b0);
      expect_word("R1 then valid", w0, 11'h099);
   endtask

   task automatic t_loopback();
      int w0;
      lb_sel = 1'b1;
      repeat (4) @(negedge clk);
      rx_pin = 1'b0;
      w0 = n_words; send(8'h6E, 8, 1'b0, 1'b0, 1'b1, 1'b1);
      expect_word("R8 loopback", w0, 11'h06E);
      hold(1'b0, 12 * BIT_CLKS, 1'b0);
      check("R8 pin ignored", n_words == w0 + 1, n_words - w0, 1);
      rx_pin = 1'b1;
      repeat (4) @(negedge clk);
      lb_sel = 1'b0;
      repeat (BIT_CLKS) @(negedge clk);
   endtask

   task automatic t_timeout();
      int p0;
      cfg_idle = 5'd2;
      p0 = n_pulse;
      send(8'h11, 8, 1'b0, 1'b0, 1'b1, 1'b0);
      repeat (1000 - 2 * BIT_CLKS) @(negedge clk);
      check("R9 not early", n_pulse == p0, n_pulse - p0, 0);
      repeat (500) @(negedge clk);
      check("R9 fired", n_pulse == p0 + 1, n_pulse - p0, 1);
      repeat (3000) @(negedge clk);
      check("R9 once", n_pulse == p0 + 1, n_pulse - p0, 1);
   endtask

   task automatic t_zero();
      int p0;
      cfg_idle = 5'd0;
      p0 = n_pulse;
      send(8'h22, 8, 1'b0, 1'b0, 1'b1, 1'b0);
      repeat (5000) @(negedge clk);
      check("R10 disabled", n_pulse == p0, n_pulse - p0, 0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_byte();
      t_short();
      t_parity();
      t_framing();
      t_break();
      t_false_start();
      t_loopback();
      t_timeout();
      t_zero();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule